// File: doc/BRIEF.md
# Serial Test Pattern Generator with Error Injection

This block is the transmit half of a bit error rate tester. It emits one bit per clock in each cycle where the clock enable is high. It can send one of three streams. The first is a repeating 32-bit word. The second is a maximal-length pseudorandom sequence of period 2^15-1. The third alternates between two 32-bit words, sending each a programmable number of times.

A 16-bit control word sets the block up. A rising edge on its load bit captures the pattern words and the generation mode, then restarts the stream. A rising edge on its error bit inverts one emitted bit. A three-bit rate code inverts one bit in every 10^k emitted bits, for k from 1 to 7. A receiver at the far end counts these errors to confirm that its error detection works.

Top module: `pattern_tx_gen`

## Requirements
- R1: After reset, and until the first load, the block emits 0 on every enabled cycle and inserts no errors.
- R2: Only a 0-to-1 transition of `ctrl[0]` loads the pattern. The load captures `word_a`, `word_b` and `mode` and restarts the stream, and that stream's first bit is emitted on the first enabled cycle after the edge. Holding `ctrl[0]` high, or changing the words or mode afterwards, has no effect until the bit is cleared and set again.
- R3: Mode 0 (repeat), and the unused mode 3, send the captured `word_a` continuously, most significant bit first.
- R4: Mode 1 (pseudorandom) starts with fifteen 1 bits after a load. Every output after that satisfies o[n+15] = o[n] XOR o[n+1], which is x^15+x^14+1. The sequence repeats every 32767 bits and never becomes all zero.
- R5: Mode 2 (alternating) sends `word_a` N+1 times, then `word_b` N+1 times, and repeats without end. N is `ctrl[15:8]`, from 0 to 255, so each word is sent 1 to 256 times.
- R6: Each 0-to-1 transition of `ctrl[4]` inverts exactly one emitted bit: the next one. Holding the bit high inserts no further errors.
- R7: The rate code `ctrl[7:5]` = 0 disables automatic insertion. A code k from 1 to 7 inverts the 10^k-th emitted bit, and every 10^k-th bit after it, counted from the last code change.
- R8: Any change of the rate code restarts the rate count from zero.
- R9: While `bit_en` is low, the stream does not advance and no error is used up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Emit/advance one bit this cycle |
| mode | input | 2 | Generation mode: 0 repeat, 1 pseudorandom, 2 alternating |
| ctrl | input | 16 | Control word: bit 0 load, bit 4 single error, bits 7:5 rate code, bits 15:8 repeat count |
| word_a | input | 32 | First pattern word |
| word_b | input | 32 | Second pattern word |
| tx_bit | output | 1 | Serial output, valid in cycles with `bit_en` high |

## Verification
The assertions assume two things about the control inputs. Strobe bits are sampled only at clock edges. The rate code changes only at clock edges and may change at any time, and the rate counter's bound is checked against the registered code rather than the live input. The stimulus changes every input at the falling clock edge. It toggles the strobe bits only while `bit_en` is low, or keeps them at a steady level, so the edge that produced each error or load is known. It changes the rate code during an idle cycle, so the restart point of the rate count is known.

// File: rtl/pattern_tx_gen_pkg.sv
package pattern_tx_gen_pkg;
   typedef enum logic [1:0] {
      GEN_REPEAT = 2'd0,
      GEN_PRBS   = 2'd1,
      GEN_ALT    = 2'd2,
      GEN_SPARE  = 2'd3
   } gen_mode_e;

   localparam int CTRL_W       = 16;
   localparam int BIT_LOAD     = 0;
   localparam int BIT_SINGLE   = 4;
   localparam int RATE_LSB     = 5;
   localparam int RATE_CODE_W  = 3;
   localparam int REP_LSB      = 8;
   localparam int REP_W        = 8;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] lvl,
   output logic [NUM-1:0] rise
);
   if (NUM < 1) begin : g_bad_num
      $error("strobe_rise: NUM must be at least 1");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_det
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[g];
      end
      assign rise[g] = lvl[g] & ~prev_q;

      // R2/R6: one level change gives a single-cycle pulse
      assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rise[g] |=> !rise[g]);
   end
endmodule

// File: rtl/decade_rate.sv
module decade_rate #(
   parameter int CODE_W = 3,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [CODE_W-1:0] code,
   output logic              fire
);
   localparam int MAX_EXP = (1 << CODE_W) - 1;

   function automatic logic [CNT_W-1:0] limit_of(input logic [CODE_W-1:0] c);
      longint v;
      v = 1;
      for (int k = 0; k < MAX_EXP; k++) begin
         if (k < int'(c)) v = v * 10;
      end
      return CNT_W'(v - 1);
   endfunction

   function automatic longint top_limit();
      longint v;
      v = 1;
      for (int k = 0; k < MAX_EXP; k++) v = v * 10;
      return v;
   endfunction

   if (top_limit() > (longint'(1) << CNT_W)) begin : g_bad_width
      $error("decade_rate: CNT_W too narrow for the largest decade");
   end

   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  lim;
   logic              code_chg;
   logic              active;

   assign lim      = limit_of(code_q);
   assign code_chg = (code != code_q);
   assign active   = (code_q != '0) && !code_chg;
   assign fire     = active && bit_en && (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         cnt_q  <= '0;
      end else if (code_chg) begin
         code_q <= code;
         cnt_q  <= '0;
      end else if (active && bit_en) begin
         if (cnt_q == lim) cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_code_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      code_chg |=> (cnt_q == '0));
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= lim));
   assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == '0) |-> !fire);
endmodule

// File: rtl/pattern_core.sv
module pattern_core
   import pattern_tx_gen_pkg::*;
#(
   parameter int                WORD_W  = 32,
   parameter int                CNT_W   = 8,
   parameter int                LFSR_W  = 15,
   parameter int                TAP_B   = 14,
   parameter logic [LFSR_W-1:0] SEED    = '1,
   parameter bit                PRBS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              load,
   input  gen_mode_e         mode_in,
   input  logic [WORD_W-1:0] word_a,
   input  logic [WORD_W-1:0] word_b,
   input  logic [CNT_W-1:0]  rep_lim,
   output logic              raw_bit
);
   localparam int IDX_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("pattern_core: WORD_W must be at least 2");
   end
   if (TAP_B >= LFSR_W || TAP_B < 1) begin : g_bad_tap
      $error("pattern_core: TAP_B must lie inside the register");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("pattern_core: SEED must be non-zero");
   end

   gen_mode_e         mode_q;
   logic [WORD_W-1:0] wa_q, wb_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  rep_q;
   logic              sel_q;
   logic [LFSR_W-1:0] lfsr_q;
   logic              word_bit;
   logic              prbs_bit;
   logic              word_end;

   assign word_end = (idx_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= GEN_REPEAT;
         wa_q   <= '0;
         wb_q   <= '0;
         idx_q  <= IDX_TOP;
         rep_q  <= '0;
         sel_q  <= 1'b0;
      end else if (load) begin
         mode_q <= mode_in;
         wa_q   <= word_a;
         wb_q   <= word_b;
         idx_q  <= IDX_TOP;
         rep_q  <= '0;
         sel_q  <= 1'b0;
      end else if (bit_en) begin
         if (word_end) begin
            idx_q <= IDX_TOP;
            if (mode_q == GEN_ALT) begin
               if (rep_q >= rep_lim) begin
                  rep_q <= '0;
                  sel_q <= ~sel_q;
               end else begin
                  rep_q <= rep_q + 1'b1;
               end
            end
         end else begin
            idx_q <= idx_q - 1'b1;
         end
      end
   end

   assign word_bit = sel_q ? wb_q[idx_q] : wa_q[idx_q];

   if (PRBS_EN) begin : g_prbs
      logic fb;
      assign fb = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP_B-1];
      always_ff @(posedge clk) begin
         if (!rst_n)      lfsr_q <= SEED;
         else if (load)   lfsr_q <= SEED;
         else if (bit_en) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      end
      assign prbs_bit = lfsr_q[LFSR_W-1];

      assert_lfsr_alive_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (lfsr_q != '0) |=> (lfsr_q != '0));
   end else begin : g_no_prbs
      assign lfsr_q   = '0;
      assign prbs_bit = 1'b0;
   end

   always_comb begin
      unique case (mode_q)
         GEN_PRBS: raw_bit = prbs_bit;
         default:  raw_bit = word_bit;
      endcase
   end

   assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (idx_q == IDX_TOP && !sel_q && rep_q == '0));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !bit_en) |=> ($stable(idx_q) && $stable(sel_q) && $stable(lfsr_q)));
   assert_single_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != GEN_ALT && !load) |=> !sel_q);
endmodule

// File: rtl/pattern_tx_gen.sv
module pattern_tx_gen
   import pattern_tx_gen_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int RATE_W  = 24,
   parameter bit PRBS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        mode,
   input  logic [15:0]       ctrl,
   input  logic [WORD_W-1:0] word_a,
   input  logic [WORD_W-1:0] word_b,
   output logic              tx_bit
);
   logic [1:0] strobe_lvl, strobe_rise_v;
   logic       load, single_req, rate_fire, pend_q, raw_bit, inject;
   logic       ctrl_unused;

   assign ctrl_unused = ^ctrl[BIT_SINGLE-1:BIT_LOAD+1];
   assign strobe_lvl  = {ctrl[BIT_SINGLE], ctrl[BIT_LOAD]};
   assign load        = strobe_rise_v[0];
   assign single_req  = strobe_rise_v[1];

   strobe_rise #(.NUM(2)) u_edges (
      .clk(clk), .rst_n(rst_n), .lvl(strobe_lvl), .rise(strobe_rise_v)
   );

   decade_rate #(.CODE_W(RATE_CODE_W), .CNT_W(RATE_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .code(ctrl[RATE_LSB +: RATE_CODE_W]), .fire(rate_fire)
   );

   pattern_core #(.WORD_W(WORD_W), .CNT_W(REP_W), .PRBS_EN(PRBS_EN)) u_core (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load),
      .mode_in(gen_mode_e'(mode)), .word_a(word_a), .word_b(word_b),
      .rep_lim(ctrl[REP_LSB +: REP_W]), .raw_bit(raw_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (single_req) pend_q <= 1'b1;
      else if (bit_en)     pend_q <= 1'b0;
   end

   assign inject = bit_en & (pend_q | rate_fire);
   assign tx_bit = raw_bit ^ inject;

   assert_single_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && bit_en && !single_req) |=> !pend_q);
   assert_pend_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !bit_en) |=> pend_q);
endmodule

// File: tb/pattern_tx_gen_test.sv
module pattern_tx_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [15:0] ctrl = 16'h0;
   logic [31:0] word_a = 32'h0, word_b = 32'h0;
   logic        tx_bit;

   int n_chk = 0, n_bad = 0;
   logic [31:0] ea, eb;
   int          ecnt;
   int          emode;
   int          pos;
   int          flips, first_flip;
   logic        bits[0:33000];

   pattern_tx_gen uut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(mode),
      .ctrl(ctrl), .word_a(word_a), .word_b(word_b), .tx_bit(tx_bit));

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic exp_bit(input int p);
      int w;
      int b;
      w = p / 32;
      b = 31 - (p % 32);
      if (emode == 2 && ((w / (ecnt + 1)) % 2 == 1)) return eb[b];
      return ea[b];
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_en = 1'b0;
      end
   endtask

   task automatic do_load(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      bit_en = 1'b0; mode = m; word_a = a; word_b = b; ctrl[0] = 1'b1;
      @(negedge clk);
      ctrl[0] = 1'b0;
      ea = a; eb = b; emode = (m == 2'd3) ? 0 : int'(m); ecnt = int'(ctrl[15:8]); pos = 0;
   endtask

   task automatic emit(input int n);
      flips = 0; first_flip = -1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_en = 1'b1;
         #1;
         if (i <= 33000) bits[i] = tx_bit;
         if (emode != 1 && tx_bit !== exp_bit(pos)) begin
            if (first_flip < 0) first_flip = i;
            flips++;
         end
         pos++;
      end
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic t_reset();
      emode = 0; ea = 0; eb = 0; ecnt = 0; pos = 0;
      emit(40);
      check(flips == 0, "R1 zero output after reset", flips, 0);
   endtask

   task automatic t_repeat();
      do_load(2'd0, 32'hC35A_0F81, 32'h0);
      emit(96);
      check(flips == 0, "R3 repeat word MSB first", flips, 0);
      do_load(2'd3, 32'h8000_0001, 32'hFFFF_FFFF);
      emit(64);
      check(flips == 0, "R3 mode 3 repeats word_a", flips, 0);
   endtask

   task automatic t_load_level();
      @(negedge clk);
      mode = 2'd0; word_a = 32'hA5F0_1234; ctrl[0] = 1'b1;
      ea = 32'hA5F0_1234; emode = 0; pos = 0;
      @(negedge clk);
      word_a = 32'h0000_FFFF; mode = 2'd1;
      emit(80);
      check(flips == 0, "R2 held load bit and new words ignored", flips, 0);
      @(negedge clk);
      ctrl[0] = 1'b0;
      emit(20);
      check(flips == 0, "R2 clearing load bit does not reload", flips, 0);
   endtask

   task automatic t_prbs();
      int bad;
      do_load(2'd1, 32'h0, 32'h0);
      emit(32767 + 40);
      bad = 0;
      for (int i = 0; i < 15; i++) if (bits[i] !== 1'b1) bad++;
      check(bad == 0, "R4 fifteen ones after load", bad, 0);
      bad = 0;
      for (int i = 0; i + 15 < 32767 + 40; i++)
         if (bits[i+15] !== (bits[i] ^ bits[i+1])) bad++;
      check(bad == 0, "R4 recurrence x^15+x^14+1", bad, 0);
      bad = 0;
      for (int i = 0; i < 40; i++) if (bits[i+32767] !== bits[i]) bad++;
      check(bad == 0, "R4 period 32767", bad, 0);
   endtask

   task automatic t_alt(input logic [7:0] c, input int n);
      ctrl[15:8] = c;
      do_load(2'd2, 32'hDEAD_BEEF, 32'h1357_9BDF);
      emit(n);
      check(flips == 0, $sformatf("R5 alternating count %0d", c), flips, 0);
   endtask

   task automatic t_hold();
      do_load(2'd2, 32'hF00F_3CC3, 32'h0FF0_C33C);
      emit(45);
      idle(7);
      emit(100);
      check(flips == 0, "R9 stream resumes after idle", flips, 0);
   endtask

   task automatic t_single();
      ctrl[15:8] = 8'd0;
      do_load(2'd0, 32'h6B2D_91E4, 32'h0);
      emit(10);
      @(negedge clk);
      bit_en = 1'b0; ctrl[4] = 1'b1;
      idle(3);
      emit(64);
      check(flips == 1, "R6 one error per rising edge", flips, 1);
      check(first_flip == 0, "R6 error on next emitted bit (R9 kept while idle)", first_flip, 0);
      emit(64);
      check(flips == 0, "R6 held level adds no error", flips, 0);
      @(negedge clk);
      ctrl[4] = 1'b0;
      emit(40);
      check(flips == 0, "R6 falling edge adds no error", flips, 0);
   endtask

   task automatic set_rate(input logic [2:0] k);
      @(negedge clk);
      bit_en = 1'b0; ctrl[7:5] = k;
      idle(1);
   endtask

   task automatic t_rate();
      do_load(2'd0, 32'h3C3C_A5A5, 32'h0);
      set_rate(3'd1);
      emit(100);
      check(flips == 10, "R7 code 1 error count", flips, 10);
      check(first_flip == 9, "R7 code 1 first error", first_flip, 9);
      set_rate(3'd2);
      emit(250);
      check(flips == 2, "R7 code 2 error count", flips, 2);
      check(first_flip == 99, "R7 code 2 first error", first_flip, 99);
      set_rate(3'd3);
      emit(500);
      check(flips == 0, "R7 code 3 no error before 1000", flips, 0);
      set_rate(3'd2);
      emit(150);
      check(first_flip == 99, "R8 count restarts on code change", first_flip, 99);
      set_rate(3'd4);
      emit(20000);
      check(flips == 2, "R7 code 4 error count", flips, 2);
      check(first_flip == 9999, "R7 code 4 first error", first_flip, 9999);
      set_rate(3'd0);
      emit(300);
      check(flips == 0, "R7 code 0 disables insertion", flips, 0);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_repeat();
      t_load_level();
      t_prbs();
      t_alt(8'd0, 256);
      t_alt(8'd2, 500);
      t_alt(8'd6, 1000);
      t_alt(8'd255, 17000);
      t_hold();
      t_single();
      t_rate();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule